// File: doc/BRIEF.md
# Serial Receiver with Mute and Idle-Line Wake-Up

This block takes an asynchronous serial line and turns each frame into a byte. A frame is one start bit, eight data bits sent least significant bit first, and one stop bit. The block counts a 16x oversampling tick that is generated elsewhere, so it has no baud generator of its own. A completed byte is written to a receive data register. The block keeps three flags: data-register-full, overrun and idle-line. Each flag can raise a shared interrupt line, and each interrupt source has its own enable. Reading the data register clears all three flags.

Software can place the receiver in a mute state. While muted, completed bytes leave the data register, the flags and the interrupt untouched. The hardware leaves the mute state when it sees an idle line, which is a full frame time of continuous logic 1 after a received byte. Because the idle line must follow a byte, wake-up only works once at least one byte has been received since the receiver was enabled. A byte received while muted also counts for this. Parity, address-mark wake-up and baud generation are not part of the block.

Top module: `serial_rx_wake`

## Requirements
- R1: When `rx_en` is 0 the line is ignored: no frame is assembled and the data register and flags do not change. Clearing `rx_en` aborts a frame in progress and discards the idle-line arming.
- R2: With `rx_en` at 1, a low level seen on an `os_tick` starts a frame. A frame is a start bit (0), 8 data bits sent LSB first, then a stop bit (1), and each bit lasts 16 ticks. A byte with a valid stop bit loads `rx_data` and sets `rx_full`. A byte whose stop bit is 0 is discarded.
- R3: The start bit is sampled 8 ticks after the tick that saw the line low. If the line is high at that point, the start is false and the receiver goes back to hunting without producing a byte.
- R4: If a byte completes while `rx_full` is 1, `rx_overrun` is set and `rx_data` keeps the older byte.
- R5: A one-cycle pulse on `data_rd` clears `rx_full`, `rx_overrun` and `line_idle`.
- R6: After a byte's stop bit has been sampled, 160 consecutive ticks with the line high set `line_idle`, once per idle period. A low level on the line restarts the count. Another idle indication needs a new byte first.
- R7: `irq` is 1 exactly when (`rx_irq_en` and (`rx_full` or `rx_overrun`)) or (`idle_irq_en` and `line_idle`).
- R8: While `rx_muted` is 1, completed bytes do not change `rx_data`, `rx_full` or `rx_overrun`, so no receive interrupt is raised.
- R9: An idle period detected while muted clears `rx_muted` and does not set `line_idle`.
- R10: An idle line wakes the receiver only if a byte, muted or not, has completed since `rx_en` last rose.
- R11: A pulse on `mute_wr` loads `mute_wdata` into `rx_muted` on the next clock. A software write wins over a hardware wake-up in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, already synchronous to `clk` |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| rx_irq_en | input | 1 | Interrupt enable for the full and overrun flags |
| idle_irq_en | input | 1 | Interrupt enable for the idle flag |
| mute_wr | input | 1 | Write strobe for the mute state |
| mute_wdata | input | 1 | Value written into the mute state |
| data_rd | input | 1 | Data-register read strobe; clears the flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Data register holds an unread byte |
| rx_overrun | output | 1 | A byte was lost because the register was full |
| line_idle | output | 1 | Idle line detected after a byte |
| rx_muted | output | 1 | Receiver is in the mute state |
| irq | output | 1 | Combined interrupt request |

## Verification
A bit counter or oversampling phase that is off by one shows up on the very next frame: `rx_data` holds a shifted or wrong byte. It is visible one clock after the stop-bit sample, about 152 ticks after the start edge. A wrongly kept mute state or idle arming shows only after a full idle period of 160 ticks. A muted receiver that never wakes, or one that wakes without a prior byte, is therefore observed at `rx_muted` roughly one frame time after the line goes quiet. Errors in the flag logic, such as an overwritten byte on overrun or a flag that the read does not clear, show at the ports one clock after the triggering byte or read.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/srx_framer.sv
`timescale 1ns/1ps
module srx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              enable,
  output logic              word_done,
  output logic [DATA_W-1:0] word
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_B  = BIT_W'(DATA_W - 1);

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  tcnt_q, tcnt_n;
  logic [BIT_W-1:0]  bcnt_q, bcnt_n;
  logic [DATA_W-1:0] shr_q, shr_n;
  logic              done_q, done_n;

  always_comb begin
    state_n = state_q;
    tcnt_n  = tcnt_q;
    bcnt_n  = bcnt_q;
    shr_n   = shr_q;
    done_n  = 1'b0;
    if (!enable) begin
      state_n = RX_HUNT;
      tcnt_n  = '0;
      bcnt_n  = '0;
    end else if (tick) begin
      unique case (state_q)
        RX_HUNT: begin
          if (!line) begin
            state_n = RX_START;
            tcnt_n  = '0;
          end
        end
        RX_START: begin
          if (tcnt_q == HALF_M1) begin
            tcnt_n  = '0;
            bcnt_n  = '0;
            state_n = line ? RX_HUNT : RX_DATA;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (tcnt_q == FULL_M1) begin
            tcnt_n = '0;
            if (DATA_W > 1) shr_n = {line, shr_q[DATA_W-1:1]};
            else            shr_n = line;
            if (bcnt_q == LAST_B) state_n = RX_STOP;
            else                  bcnt_n  = bcnt_q + 1'b1;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tcnt_q == FULL_M1) begin
            tcnt_n  = '0;
            state_n = RX_HUNT;
            done_n  = line;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        default: state_n = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      tcnt_q  <= tcnt_n;
      bcnt_q  <= bcnt_n;
      shr_q   <= shr_n;
      done_q  <= done_n;
    end
  end

  assign word_done = done_q;
  assign word      = shr_q;
endmodule

// File: rtl/srx_idle.sv
`timescale 1ns/1ps
module srx_idle #(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic enable,
  input  logic word_done,
  output logic idle_pulse
);
  localparam int IDLE_TICKS = OSR * IDLE_BITS;
  localparam int IW         = $clog2(IDLE_TICKS + 1);
  localparam logic [IW-1:0] LAST = IW'(IDLE_TICKS - 1);

  logic          armed_q, armed_n;
  logic [IW-1:0] cnt_q, cnt_n;
  logic          pls_q, pls_n;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    pls_n   = 1'b0;
    if (!enable) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else if (word_done) begin
      armed_n = 1'b1;
      cnt_n   = '0;
    end else if (tick && armed_q) begin
      if (!line) begin
        cnt_n = '0;
      end else if (cnt_q == LAST) begin
        pls_n   = 1'b1;
        armed_n = 1'b0;
        cnt_n   = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pls_q   <= 1'b0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      pls_q   <= pls_n;
    end
  end

  assign idle_pulse = pls_q;
endmodule

// File: rtl/srx_regs.sv
`timescale 1ns/1ps
module srx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [DATA_W-1:0] word,
  input  logic              idle_pulse,
  input  logic              data_rd,
  input  logic              mute_wr,
  input  logic              mute_wdata,
  input  logic              rie,
  input  logic              ilie,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              ovr,
  output logic              idle,
  output logic              muted,
  output logic              irq
);
  logic              full_n, ovr_n, idle_n, muted_n, load_en;
  logic [DATA_W-1:0] data_q;
  logic              full_q, ovr_q, idle_q, muted_q;

  always_comb begin
    full_n  = full_q;
    ovr_n   = ovr_q;
    idle_n  = idle_q;
    muted_n = muted_q;
    load_en = 1'b0;
    if (data_rd) begin
      full_n = 1'b0;
      ovr_n  = 1'b0;
      idle_n = 1'b0;
    end
    if (word_done && !muted_q) begin
      if (full_q && !data_rd) begin
        ovr_n = 1'b1;
      end else begin
        load_en = 1'b1;
        full_n  = 1'b1;
      end
    end
    if (idle_pulse) begin
      if (muted_q) muted_n = 1'b0;
      else         idle_n  = 1'b1;
    end
    if (mute_wr) muted_n = mute_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      idle_q  <= 1'b0;
      muted_q <= 1'b0;
    end else begin
      full_q  <= full_n;
      ovr_q   <= ovr_n;
      idle_q  <= idle_n;
      muted_q <= muted_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= word;
  end

  assign data  = data_q;
  assign full  = full_q;
  assign ovr   = ovr_q;
  assign idle  = idle_q;
  assign muted = muted_q;
  assign irq   = (rie & (full_q | ovr_q)) | (ilie & idle_q);
endmodule

// File: rtl/serial_rx_wake.sv
`timescale 1ns/1ps
module serial_rx_wake #(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              rx_en,
  input  logic              rx_irq_en,
  input  logic              idle_irq_en,
  input  logic              mute_wr,
  input  logic              mute_wdata,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              line_idle,
  output logic              rx_muted,
  output logic              irq
);
  logic              word_done;
  logic [DATA_W-1:0] word;
  logic              idle_pulse;

  srx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(rx_line),
    .enable(rx_en), .word_done(word_done), .word(word)
  );

  srx_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(rx_line),
    .enable(rx_en), .word_done(word_done), .idle_pulse(idle_pulse)
  );

  srx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word),
    .idle_pulse(idle_pulse), .data_rd(data_rd), .mute_wr(mute_wr),
    .mute_wdata(mute_wdata), .rie(rx_irq_en), .ilie(idle_irq_en),
    .data(rx_data), .full(rx_full), .ovr(rx_overrun), .idle(line_idle),
    .muted(rx_muted), .irq(irq)
  );
endmodule

// File: rtl/serial_rx_wake_chk.sv
`timescale 1ns/1ps
module serial_rx_wake_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              data_rd,
  input logic              mute_wr,
  input logic              mute_wdata,
  input logic              word_done,
  input logic              idle_pulse,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              rx_overrun,
  input logic              line_idle,
  input logic              rx_muted
);
  // R1
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !word_done);

  // R4
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !rx_muted && rx_full && !data_rd |=> rx_overrun && $stable(rx_data));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !word_done && !idle_pulse |=> !rx_full && !rx_overrun && !line_idle);

  // R6
  idle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse && !rx_muted |=> line_idle);

  // R8
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && rx_muted && !data_rd |=> $stable(rx_data) && $stable(rx_full) && $stable(rx_overrun));

  // R9
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse && rx_muted && !mute_wr && !data_rd |=> !rx_muted && $stable(line_idle));

  // R11
  mute_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_wr |=> rx_muted == $past(mute_wdata));
endmodule

bind serial_rx_wake serial_rx_wake_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .data_rd(data_rd),
  .mute_wr(mute_wr), .mute_wdata(mute_wdata), .word_done(word_done),
  .idle_pulse(idle_pulse), .rx_data(rx_data), .rx_full(rx_full),
  .rx_overrun(rx_overrun), .line_idle(line_idle), .rx_muted(rx_muted)
);

// File: tb/serial_rx_wake_bench.sv
`timescale 1ns/1ps
module serial_rx_wake_bench;
  logic       clk, rst_n, rx_line, os_tick, rx_en, rx_irq_en, idle_irq_en;
  logic       mute_wr, mute_wdata, data_rd;
  logic [7:0] rx_data;
  logic       rx_full, rx_overrun, line_idle, rx_muted, irq;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  serial_rx_wake u_serial_rx_wake (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .rx_en(rx_en), .rx_irq_en(rx_irq_en), .idle_irq_en(idle_irq_en),
    .mute_wr(mute_wr), .mute_wdata(mute_wdata), .data_rd(data_rd),
    .rx_data(rx_data), .rx_full(rx_full), .rx_overrun(rx_overrun),
    .line_idle(line_idle), .rx_muted(rx_muted), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      forever begin
        @(posedge clk);
        if (os_tick) break;
      end
    end
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop = 1'b1);
    rx_line = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      wait_ticks(16);
    end
    rx_line = stop;
    wait_ticks(16);
    rx_line = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_data();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_mute(input logic v);
    @(negedge clk); mute_wr = 1'b1; mute_wdata = v;
    @(negedge clk); mute_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    wait_ticks(200);
    read_data();
  endtask

  task automatic t_reset();
    chk("R5 reset full", rx_full, 0);
    chk("R5 reset overrun", rx_overrun, 0);
    chk("R6 reset idle", line_idle, 0);
    chk("R11 reset muted", rx_muted, 0);
    chk("R7 reset irq", irq, 0);
  endtask

  task automatic t_basic();
    send_byte(8'hA5);
    chk("R2 data A5", rx_data, 8'hA5);
    chk("R2 full set", rx_full, 1);
    chk("R7 irq from full", irq, 1);
    read_data();
    chk("R5 read clears full", rx_full, 0);
    chk("R7 irq drops", irq, 0);
    wait_ticks(8);
    send_byte(8'h80);
    chk("R2 data 80 (LSB first)", rx_data, 8'h80);
    settle();
    send_byte(8'h5A, 1'b0);
    chk("R2 bad stop discarded", rx_full, 0);
    settle();
  endtask

  task automatic t_overrun();
    send_byte(8'h3C);
    wait_ticks(4);
    send_byte(8'hC3);
    chk("R4 overrun set", rx_overrun, 1);
    chk("R4 older byte kept", rx_data, 8'h3C);
    read_data();
    chk("R5 read clears overrun", rx_overrun, 0);
    settle();
  endtask

  task automatic t_idle();
    rx_irq_en = 1'b0;
    idle_irq_en = 1'b1;
    send_byte(8'h21);
    read_data();
    wait_ticks(100);
    chk("R6 no idle before 160 ticks", line_idle, 0);
    wait_ticks(70);
    chk("R6 idle set", line_idle, 1);
    chk("R7 irq from idle", irq, 1);
    idle_irq_en = 1'b0;
    @(negedge clk);
    chk("R7 idle irq masked", irq, 0);
    idle_irq_en = 1'b1;
    read_data();
    chk("R5 read clears idle", line_idle, 0);
    wait_ticks(250);
    chk("R6 idle once per period", line_idle, 0);
    rx_irq_en = 1'b1;
    idle_irq_en = 1'b0;
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    send_byte(8'h77);
    chk("R1 disabled ignores line", rx_full, 0);
    wait_ticks(200);
    chk("R1 disabled no idle", line_idle, 0);
    rx_en = 1'b1;
    wait_ticks(4);
  endtask

  task automatic t_false_start();
    rx_line = 1'b0;
    wait_ticks(3);
    rx_line = 1'b1;
    wait_ticks(40);
    chk("R3 false start gives no byte", rx_full, 0);
    send_byte(8'h96);
    chk("R3 next byte after false start", rx_data, 8'h96);
    settle();
  endtask

  task automatic t_mute();
    send_byte(8'h0F);
    read_data();
    write_mute(1'b1);
    chk("R11 mute written", rx_muted, 1);
    send_byte(8'h99);
    chk("R8 muted full unchanged", rx_full, 0);
    chk("R8 muted data unchanged", rx_data, 8'h0F);
    chk("R8 muted irq low", irq, 0);
    chk("R9 still muted before idle", rx_muted, 1);
    wait_ticks(200);
    chk("R9 idle wakes", rx_muted, 0);
    chk("R9 idle flag not set on wake", line_idle, 0);
    send_byte(8'h42);
    chk("R9 byte after wake stored", rx_data, 8'h42);
    settle();
  endtask

  task automatic t_wake_needs_word();
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    write_mute(1'b1);
    wait_ticks(300);
    chk("R10 no wake without byte", rx_muted, 1);
    send_byte(8'h11);
    chk("R10 muted byte not stored", rx_full, 0);
    wait_ticks(200);
    chk("R10 wake after muted byte", rx_muted, 0);
    write_mute(1'b1);
    write_mute(1'b0);
    chk("R11 software clear", rx_muted, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; rx_en = 1'b1;
    rx_irq_en = 1'b1; idle_irq_en = 1'b0;
    mute_wr = 1'b0; mute_wdata = 1'b0; data_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_overrun();
    t_idle();
    t_disabled();
    t_false_start();
    t_mute();
    t_wake_needs_word();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule